// File: doc/BRIEF.md
# Majority-vote asynchronous serial receiver

This block receives characters from an asynchronous serial line. It is driven by an external rate generator. That generator supplies a one-cycle oversample tick at 16 times the bit rate, or at 8 times the bit rate when the double-speed input is set. The block watches the synchronized line for a falling edge that follows a high sample. It then counts oversamples from that edge and decides every bit, the start bit included, by a two-of-three vote of the centre samples. If the start bit votes high, the receiver treats it as a noise spike and goes back to idle. Otherwise it collects 5 to 9 data bits, least significant bit first. An optional even or odd parity bit follows, and after it the first stop bit is decided.

Each finished character goes into a two-entry buffer, together with its frame-error and parity-error flags. A character that finishes while the buffer is full is dropped, and the overrun output goes high. The flow-control output `rts` stays high while the buffer has room. Only the first stop bit is sampled: a sender that uses two stop bits only lengthens the idle gap. Clearing `rx_en` aborts any frame in progress and empties the buffer. Format inputs must be held steady while a frame is being received.

Top module: `uart_rx_mv`

## Requirements
- R1: After reset `rx_avail` is 0, `ovr` is 0 and `rts` is 1.
- R2: A frame starts only on a tick whose sampled line is low while the sampled line was high at the previous tick. A line that is already low when the receiver is reset or enabled starts no frame until it has been seen high.
- R3: With `dbl_speed` = 0 a bit lasts 16 ticks, and with `dbl_speed` = 1 it lasts 8 ticks. The detection tick is sample 0. Each bit is the majority of its samples 7, 8 and 9 (or 3, 4 and 5 at double speed), so one wrong centre sample does not change the result.
- R4: If the start bit votes high, the receiver returns to idle and stores nothing.
- R5: `data_bits` selects the number of data bits. Values below 5 act as 5, and values above 9 act as 9. Data arrive least significant bit first and appear right-aligned on `rd_data`, with the unused upper bits at 0.
- R6: `par_mode` 0x means no parity bit, 10 means even parity and 11 means odd parity. When parity is enabled, `rd_perr` is 1 for a character whose data bits and parity bit do not satisfy the selected parity.
- R7: If the first stop bit votes low, the character is still stored, with `rd_ferr` = 1.
- R8: The buffer holds two characters and returns them in arrival order. `rd_data`, `rd_perr` and `rd_ferr` show the oldest one. A one-cycle `rd` while `rx_avail` = 1 removes it. `rx_avail` stays 1 while any character is unread, and `rd` on an empty buffer has no effect.
- R9: A character that finishes while two characters are held, with no read in the same cycle, is dropped and sets `ovr`. `ovr` clears on the next read that removes a character.
- R10: `rts` is 0 exactly while two characters are held. It returns to 1 in the cycle after the read that frees an entry.
- R11: While `rx_en` = 0 the buffer is empty, `ovr` is 0 and any partly received frame is discarded.
- R12: A character becomes visible in the clock cycle after the tick on which its stop bit is decided.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| os_tick | input | 1 | One-cycle oversample strobe from the rate generator |
| rx_en | input | 1 | Receiver enable; low flushes and aborts |
| dbl_speed | input | 1 | 1: 8 samples per bit, 0: 16 samples per bit |
| data_bits | input | 4 | Data bits per character (5..9, clamped) |
| par_mode | input | 2 | 0x none, 10 even, 11 odd |
| rxd | input | 1 | Serial line, idle high |
| rd | input | 1 | Read strobe, removes the oldest character |
| rd_data | output | 9 | Oldest character, right-aligned |
| rd_ferr | output | 1 | Frame error of the oldest character |
| rd_perr | output | 1 | Parity error of the oldest character |
| rx_avail | output | 1 | At least one unread character |
| ovr | output | 1 | A character was dropped on a full buffer |
| rts | output | 1 | High while the buffer can accept a character |

## Verification
The hardest states to reach from the ports are the vote boundaries. They are a single corrupted centre sample inside a bit, and a start pulse that is low at detection but high over the voting window. They are also the only places where the vote makes a difference. The bench builds every frame tick by tick and chooses the line level for each individual oversample. It can therefore invert exactly one centre sample per bit, or hold the line low for only three ticks. The overrun case needs a third frame to finish against a full buffer with no read pending, so the bench sends three characters back to back without reading.

// File: rtl/uart_rx_mv.sv
`timescale 1ns/1ps
module uart_rx_mv (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       os_tick,
  input  logic       rx_en,
  input  logic       dbl_speed,
  input  logic [3:0] data_bits,
  input  logic [1:0] par_mode,
  input  logic       rxd,
  input  logic       rd,
  output logic [8:0] rd_data,
  output logic       rd_ferr,
  output logic       rd_perr,
  output logic       rx_avail,
  output logic       ovr,
  output logic       rts
);
  localparam int DW = 9;
  localparam int EW = DW + 2;

  logic [1:0]    sync;
  logic          last_s, busy, v0, v1, pbit;
  logic [3:0]    cnt, bitn, nd;
  logic [DW-1:0] sreg;
  logic [EW-1:0] buf0, buf1;
  logic [1:0]    count;

  wire rx_s = sync[1];

  always_comb begin
    if (data_bits < 4'd5)      nd = 4'd5;
    else if (data_bits > 4'd9) nd = 4'd9;
    else                       nd = data_bits;
  end

  wire          par_en   = par_mode[1];
  wire [3:0]    mid      = dbl_speed ? 4'd3 : 4'd7;
  wire [3:0]    last_cnt = dbl_speed ? 4'd7 : 4'd15;
  wire [3:0]    stop_idx = nd + {3'b000, par_en} + 4'd1;
  wire          decide   = busy && os_tick && (cnt == mid + 4'd2);
  wire          maj      = (v0 & v1) | (v0 & rx_s) | (v1 & rx_s);
  wire          at_stop  = decide && (bitn == stop_idx);
  wire          pop      = rd && (count != 2'd0);
  wire          push_ok  = at_stop && ((count != 2'd2) || pop);
  wire [DW-1:0] dalign   = sreg >> (4'd9 - nd);
  wire          perr_n   = par_en && ((^dalign) ^ pbit ^ par_mode[0]);
  wire [EW-1:0] entry    = {~maj, perr_n, dalign};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync <= 2'b11; last_s <= 1'b0; busy <= 1'b0;
      cnt <= '0; bitn <= '0; v0 <= 1'b0; v1 <= 1'b0; pbit <= 1'b0; sreg <= '0;
    end else begin
      sync <= {sync[0], rxd};
      if (!rx_en) begin
        busy <= 1'b0; last_s <= 1'b0;
      end else if (os_tick) begin
        last_s <= rx_s;
        if (!busy) begin
          if (last_s && !rx_s) begin
            busy <= 1'b1; cnt <= 4'd1; bitn <= 4'd0;
          end
        end else begin
          if (cnt == mid)         v0 <= rx_s;
          if (cnt == mid + 4'd1)  v1 <= rx_s;
          if (decide) begin
            if (bitn == 4'd0) begin
              if (maj) busy <= 1'b0;
            end else if (bitn == stop_idx) busy <= 1'b0;
            else if (bitn > nd)          pbit <= maj;
            else                         sreg <= {maj, sreg[DW-1:1]};
          end
          if (cnt == last_cnt) begin
            cnt <= 4'd0; bitn <= bitn + 4'd1;
          end else cnt <= cnt + 4'd1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= 2'd0; ovr <= 1'b0; buf0 <= '0; buf1 <= '0;
    end else if (!rx_en) begin
      count <= 2'd0; ovr <= 1'b0;
    end else begin
      if (pop) buf0 <= buf1;
      case ({push_ok, pop})
        2'b10: begin
          if (count == 2'd0) buf0 <= entry; else buf1 <= entry;
          count <= count + 2'd1;
        end
        2'b01: count <= count - 2'd1;
        2'b11: if (count == 2'd1) buf0 <= entry; else buf1 <= entry;
        default: ;
      endcase
      if (at_stop && !push_ok) ovr <= 1'b1;
      else if (pop)            ovr <= 1'b0;
    end
  end

  assign rd_data  = buf0[DW-1:0];
  assign rd_perr  = buf0[DW];
  assign rd_ferr  = buf0[DW+1];
  assign rx_avail = (count != 2'd0);
  assign rts      = (count != 2'd2);

  AST_FLUSH_ON_DISABLE: assert property (@(posedge clk) disable iff (!rst_n) !rx_en |=> (!rx_avail && !ovr)); // R11
  AST_ABORT_ON_DISABLE: assert property (@(posedge clk) disable iff (!rst_n) !rx_en |=> !busy); // R11
  AST_OVR_ONLY_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n) $rose(ovr) |-> ($past(count) == 2'd2)); // R9
  AST_NO_SILENT_POP: assert property (@(posedge clk) disable iff (!rst_n) (count < $past(count)) |-> ($past(rd) || !$past(rx_en))); // R8
  AST_RTS_BACK_ON_READ: assert property (@(posedge clk) disable iff (!rst_n) $rose(rts) |-> ($past(rd) || !$past(rx_en))); // R10
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) count != 2'd3); // R8
endmodule

// File: tb/sim_uart_rx_mv.sv
`timescale 1ns/1ps
module sim_uart_rx_mv;
  logic clk = 0, rst_n = 0, os_tick = 0, rx_en = 0, dbl_speed = 0, rxd = 1, rd = 0;
  logic [3:0] data_bits = 4'd8;
  logic [1:0] par_mode = 2'b00;
  logic [8:0] rd_data;
  logic rd_ferr, rd_perr, rx_avail, ovr, rts;
  int checks = 0, failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  uart_rx_mv u0 (.clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rx_en(rx_en),
    .dbl_speed(dbl_speed), .data_bits(data_bits), .par_mode(par_mode), .rxd(rxd),
    .rd(rd), .rd_data(rd_data), .rd_ferr(rd_ferr), .rd_perr(rd_perr),
    .rx_avail(rx_avail), .ovr(ovr), .rts(rts));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int eff_nd();
    if (data_bits < 5) return 5;
    if (data_bits > 9) return 9;
    return int'(data_bits);
  endfunction

  // behavioural reference model
  logic [10:0] mq[$];
  bit m_ovr, m_busy, m_last, mpar;
  int m_pos;
  bit ms[16];
  bit mbits[$];

  task automatic m_step(input bit v);
    int n, mid, w, b, nd, ones;
    bit mj, perr;
    logic [8:0] d;
    n = dbl_speed ? 8 : 16;
    mid = n / 2 - 1;
    if (!m_busy) begin
      if (m_last && !v) begin m_busy = 1; m_pos = 0; mbits.delete(); end
    end else begin
      m_pos++;
      w = m_pos % n;
      b = m_pos / n;
      ms[w] = v;
      if (w == mid + 2) begin
        mj = (ms[mid] & ms[mid+1]) | (ms[mid] & v) | (ms[mid+1] & v);
        nd = eff_nd();
        if (b == 0) begin
          if (mj) m_busy = 0;
        end else if (b <= nd) mbits.push_back(mj);
        else if (b == nd + 1 && par_mode[1]) mpar = mj;
        else begin
          d = '0;
          for (int i = 0; i < nd; i++) d[i] = mbits[i];
          ones = $countones(d) + int'(mpar);
          perr = par_mode[1] && ((ones % 2) != int'(par_mode[0]));
          if (mq.size() < 2) mq.push_back({~mj, perr, d});
          else m_ovr = 1;
          m_busy = 0;
        end
      end
    end
    m_last = v;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      mq.delete(); m_ovr = 0; m_busy = 0; m_last = 0;
    end else if (!rx_en) begin
      mq.delete(); m_ovr = 0; m_busy = 0; m_last = 0;
    end else begin
      if (rd && mq.size() > 0) begin void'(mq.pop_front()); m_ovr = 0; end
      if (os_tick) m_step(rxd);
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(rx_avail == (mq.size() != 0), "R8 R12 model avail", rx_avail, mq.size() != 0);
      check(rts == (mq.size() < 2), "R10 model rts", rts, mq.size() < 2);
      check(ovr == m_ovr, "R9 model ovr", ovr, m_ovr);
      if (mq.size() != 0)
        check({rd_ferr, rd_perr, rd_data} == mq[0], "R5 R6 R7 model head",
              {rd_ferr, rd_perr, rd_data}, mq[0]);
    end
  end

  task automatic do_tick(input bit v);
    @(negedge clk); rxd = v; os_tick = 0;
    @(negedge clk);
    @(negedge clk);
    @(negedge clk); os_tick = 1;
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) do_tick(1);
  endtask

  task automatic set_en(input bit v);
    @(negedge clk); os_tick = 0; rx_en = v;
    @(negedge clk);
  endtask

  task automatic frame(input int val, input bit badpar, input bit flip, input bit stopv);
    int n, mid, nd;
    bit seq[$];
    bit p, v;
    n = dbl_speed ? 8 : 16;
    mid = n / 2 - 1;
    nd = eff_nd();
    seq.push_back(0);
    p = par_mode[0] ^ badpar;
    for (int i = 0; i < nd; i++) begin seq.push_back(val[i]); p ^= val[i]; end
    if (par_mode[1]) seq.push_back(p);
    seq.push_back(stopv);
    for (int k = 0; k < seq.size(); k++)
      for (int w = 0; w < n; w++) begin
        v = seq[k];
        if (flip && w == mid + 1) v = ~v;
        if (flip && k > 0 && k < seq.size() - 1 && w == 1) v = ~v;
        do_tick(v);
      end
    idle(2);
  endtask

  task automatic rd_expect(input int exp, input bit ep, input bit ef, input string tag);
    @(negedge clk); os_tick = 0;
    check(rx_avail === 1'b1, {tag, " avail"}, rx_avail, 1);
    check(rd_data == exp[8:0], {tag, " data"}, rd_data, exp);
    check(rd_perr == ep, {tag, " perr"}, rd_perr, ep);
    check(rd_ferr == ef, {tag, " ferr"}, rd_ferr, ef);
    rd = 1;
    @(negedge clk); rd = 0;
  endtask

  task automatic expect_empty(input string tag);
    @(negedge clk); os_tick = 0;
    check(rx_avail === 1'b0, tag, rx_avail, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    check(rx_avail === 1'b0, "R1 reset avail", rx_avail, 0);
    check(rts === 1'b1, "R1 reset rts", rts, 1);
    check(ovr === 1'b0, "R1 reset ovr", ovr, 0);
    set_en(1);
    idle(3);

    frame(9'h0A5, 0, 0, 1);
    rd_expect(9'h0A5, 0, 0, "R3 R5 8N1");

    do_tick(0); do_tick(0); do_tick(0); idle(30);
    expect_empty("R4 glitch ignored");
    frame(9'h03C, 0, 0, 1);
    rd_expect(9'h03C, 0, 0, "R4 after glitch");

    frame(9'h096, 0, 1, 1);
    rd_expect(9'h096, 0, 0, "R3 vote with one bad centre sample");

    dbl_speed = 1; data_bits = 4'd7; par_mode = 2'b10;
    frame(9'h055, 0, 1, 1);
    rd_expect(9'h055, 0, 0, "R3 R6 double speed even");
    frame(9'h013, 1, 0, 1);
    rd_expect(9'h013, 1, 0, "R6 even mismatch");

    dbl_speed = 0; data_bits = 4'd9; par_mode = 2'b11;
    frame(9'h1C3, 1, 0, 1);
    rd_expect(9'h1C3, 1, 0, "R6 odd mismatch");
    frame(9'h0F0, 0, 0, 1);
    rd_expect(9'h0F0, 0, 0, "R6 odd ok");

    par_mode = 2'b00; data_bits = 4'd2;
    frame(9'h035, 0, 0, 1);
    rd_expect(9'h015, 0, 0, "R5 clamp to five");
    data_bits = 4'd15;
    frame(9'h1AB, 0, 0, 1);
    rd_expect(9'h1AB, 0, 0, "R5 clamp to nine");

    data_bits = 4'd8;
    frame(9'h042, 0, 0, 0);
    rd_expect(9'h042, 0, 1, "R7 frame error");

    frame(9'h011, 0, 0, 1);
    frame(9'h022, 0, 0, 1);
    @(negedge clk); os_tick = 0;
    check(rts === 1'b0, "R10 rts low when full", rts, 0);
    frame(9'h033, 0, 0, 1);
    @(negedge clk); os_tick = 0;
    check(ovr === 1'b1, "R9 overrun set", ovr, 1);
    rd_expect(9'h011, 0, 0, "R8 order first");
    check(ovr === 1'b0, "R9 overrun cleared", ovr, 0);
    check(rts === 1'b1, "R10 rts back", rts, 1);
    rd_expect(9'h022, 0, 0, "R8 order second");
    expect_empty("R8 empty after reads");
    rd = 1; @(negedge clk); rd = 0;
    check(rx_avail === 1'b0 && rts === 1'b1, "R8 read on empty", rx_avail, 0);

    frame(9'h044, 0, 0, 1);
    frame(9'h045, 0, 0, 1);
    set_en(0);
    check(rx_avail === 1'b0, "R11 flushed", rx_avail, 0);
    check(rts === 1'b1, "R11 rts after flush", rts, 1);
    set_en(1);
    idle(2);
    for (int i = 0; i < 20; i++) do_tick(0);
    do_tick(1); do_tick(0); do_tick(1);
    set_en(0);
    idle(4);
    set_en(1);
    idle(3);
    expect_empty("R11 partial frame dropped");
    frame(9'h066, 0, 0, 1);
    rd_expect(9'h066, 0, 0, "R11 after abort");

    set_en(0);
    do_tick(0); do_tick(0);
    set_en(1);
    for (int i = 0; i < 40; i++) do_tick(0);
    expect_empty("R2 low line at enable");
    idle(2);
    frame(9'h077, 0, 0, 1);
    rd_expect(9'h077, 0, 0, "R2 R12 start after high");

    idle(4);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1600000;
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL R12 watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule